// File: doc/BRIEF.md
# Programmable Signature Verifier

This block compacts the parallel response words coming out of a core under test into a multiple-input signature register (MISR). At the end of a test it checks the compacted result against a golden signature. A processor drives it through a small register interface for each test. The processor loads a feedback polynomial and a starting seed, and it switches the block between compacting and verifying. It also writes the expected signature and reads back a status word that carries the verdict flags and the live signature.

A test runs as follows:
1. The processor writes the polynomial.
2. It writes the seed. This also clears any previous verdict.
3. It streams response words through the valid-qualified data input.
4. It writes the golden value.
5. It issues a verify command.
6. One cycle after the command, the block compares its signature with the golden value. It raises a done flag, and it raises a pass flag when the two match.

While the block is in verify mode, the signature is frozen and incoming words are dropped.

Top module: `sig_verifier`

## Requirements
- R1: After reset the signature, done and pass are all 0, the polynomial register reads 0, and the mode is compact.
- R2: In compact mode, each cycle with `rsp_valid` high updates the signature to `{sig[W-2:0],0} ^ (sig[W-1] ? poly : 0) ^ rsp_data`. A cycle with `rsp_valid` low leaves the signature unchanged.
- R3: A write to address 1 (seed) sets the signature to the written value on that edge and clears done and pass.
- R4: The value written to address 0 is the feedback mask used by every later update. Different polynomials produce different signatures from the same stream.
- R5: Writing address 3 with bit 0 = 1 selects verify mode and issues a compare. Done stays 0 at the write edge and reads 1 after the following edge.
- R6: The compare sets pass to 1 when the signature equals the golden value written at address 2, and to 0 otherwise. Done is set in both cases.
- R7: Response words arriving in verify mode do not change the signature.
- R8: A read of address 3 returns `{done, pass, signature}` on `reg_rdata`. Reads of addresses 0, 1 and 2 return the polynomial, seed and golden registers, zero-extended by two bits.
- R9: Writing address 3 with bit 0 = 0 returns the block to compact mode. Compaction resumes, and done and pass keep their values until the next seed write.
- R10: A seed write wins over a valid response word in the same cycle. The signature takes the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 poly, 1 seed, 2 golden, 3 control/status) |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W+2 | Combinational read data for `reg_addr` |
| rsp_valid | input | 1 | Response word valid |
| rsp_data | input | W | Response word from the core under test |

## Verification
A wrong MISR state never shows up at a verdict flag by itself. It shows up in the status read as soon as the edge that corrupted it has passed, so the bench reads the signature after every stimulus group and compares it with a bit-serial model. A wrong polynomial or a missed feedback tap makes the signature diverge within one word once the top bit is set, which is why the seeds chosen have that bit high. A fault in the compare path appears as a wrong done or pass exactly one cycle after the verify command. A leak of words in verify mode appears in the next status read.

// File: rtl/sig_verifier_pkg.sv
package sig_verifier_pkg;

  typedef enum logic [1:0] {
    ADR_POLY = 2'd0,
    ADR_SEED = 2'd1,
    ADR_GOLD = 2'd2,
    ADR_CTRL = 2'd3
  } reg_adr_e;

  typedef enum logic {
    MD_COMPACT = 1'b0,
    MD_VERIFY  = 1'b1
  } sv_mode_e;

  typedef struct packed {
    logic done;
    logic pass;
  } verdict_t;

endpackage

// File: rtl/sig_misr_core.sv
module sig_misr_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         step_en,
  input  logic [W-1:0] step_data,
  input  logic [W-1:0] poly,
  output logic [W-1:0] state
);

  // One compaction step: shift left, fold feedback mask when msb falls out, mix the word.
  function automatic logic [W-1:0] misr_next(input logic [W-1:0] s,
                                             input logic [W-1:0] p,
                                             input logic [W-1:0] d);
    logic [W-1:0] sh;
    sh = {s[W-2:0], 1'b0};
    if (s[W-1]) sh = sh ^ p;
    return sh ^ d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= '0;
    else if (load_en) state <= load_val;
    else if (step_en) state <= misr_next(state, poly, step_data);
  end

  // R3 / R10: a load always lands, even with a step request on the same edge
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> state == $past(load_val));

  // R2: no load and no step leaves the signature alone
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> $stable(state));

endmodule

// File: rtl/sig_cfg_regs.sv
module sig_cfg_regs
  import sig_verifier_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] poly_q,
  output logic [W-1:0] seed_q,
  output logic [W-1:0] gold_q,
  output sv_mode_e     mode_q,
  output logic         seed_wr,
  output logic         verify_cmd
);

  reg_adr_e adr;
  assign adr        = reg_adr_e'(reg_addr);
  assign seed_wr    = reg_we && (adr == ADR_SEED);
  assign verify_cmd = reg_we && (adr == ADR_CTRL) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q <= '0;
      seed_q <= '0;
      gold_q <= '0;
      mode_q <= MD_COMPACT;
    end else if (reg_we) begin
      case (adr)
        ADR_POLY: poly_q <= reg_wdata;
        ADR_SEED: seed_q <= reg_wdata;
        ADR_GOLD: gold_q <= reg_wdata;
        ADR_CTRL: mode_q <= sv_mode_e'(reg_wdata[0]);
        default:  ;
      endcase
    end
  end

  // R5: a verify command leaves the block in verify mode
  a_r5_cmd_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    verify_cmd |=> mode_q == MD_VERIFY);

  // R9: a control write with bit 0 low selects compact mode
  a_r9_back_to_compact: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && adr == ADR_CTRL && !reg_wdata[0]) |=> mode_q == MD_COMPACT);

endmodule

// File: rtl/sig_judge.sv
module sig_judge
  import sig_verifier_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         cmd,
  input  logic [W-1:0] sig,
  input  logic [W-1:0] gold,
  output verdict_t     verdict
);

  logic cmp_pend;
  logic cmp_fire;
  logic sig_match;

  assign cmp_fire  = cmp_pend && !clr;
  assign sig_match = (sig == gold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_pend <= 1'b0;
      verdict  <= '0;
    end else begin
      cmp_pend <= cmd;
      if (clr) begin
        verdict <= '0;
      end else if (cmp_pend) begin
        verdict.done <= 1'b1;
        verdict.pass <= sig_match;
      end
    end
  end

  // R5: the compare completes on the edge after the command edge
  a_r5_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> verdict.done);

  // R5: done never rises without a pending compare
  a_r5_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!verdict.done && !cmp_pend) |=> !verdict.done);

  // R6: pass reflects the equality seen at the compare edge
  a_r6_pass_matches: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> verdict.pass == ($past(sig) == $past(gold)));

  // R3: a seed write wipes the verdict
  a_r3_seed_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!verdict.done && !verdict.pass));

  // R6: pass is only ever seen together with done
  a_r6_pass_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
    verdict.pass |-> verdict.done);

endmodule

// File: rtl/sig_verifier.sv
module sig_verifier
  import sig_verifier_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W+1:0] reg_rdata,
  input  logic         rsp_valid,
  input  logic [W-1:0] rsp_data
);

  logic [W-1:0] poly_q, seed_q, gold_q, sig_q;
  sv_mode_e     mode_q;
  logic         seed_wr, verify_cmd, step_en;
  verdict_t     verdict;

  sig_cfg_regs #(.W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .poly_q(poly_q), .seed_q(seed_q), .gold_q(gold_q), .mode_q(mode_q),
    .seed_wr(seed_wr), .verify_cmd(verify_cmd)
  );

  assign step_en = rsp_valid && (mode_q == MD_COMPACT) && !seed_wr;

  sig_misr_core #(.W(W)) u_misr (
    .clk(clk), .rst_n(rst_n),
    .load_en(seed_wr), .load_val(reg_wdata),
    .step_en(step_en), .step_data(rsp_data),
    .poly(poly_q), .state(sig_q)
  );

  sig_judge #(.W(W)) u_judge (
    .clk(clk), .rst_n(rst_n),
    .clr(seed_wr), .cmd(verify_cmd),
    .sig(sig_q), .gold(gold_q),
    .verdict(verdict)
  );

  always_comb begin
    case (reg_adr_e'(reg_addr))
      ADR_POLY: reg_rdata = {2'b00, poly_q};
      ADR_SEED: reg_rdata = {2'b00, seed_q};
      ADR_GOLD: reg_rdata = {2'b00, gold_q};
      default:  reg_rdata = {verdict.done, verdict.pass, sig_q};
    endcase
  end

  // R7: in verify mode, response words cannot move the signature
  a_r7_verify_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_VERIFY && !seed_wr) |=> $stable(sig_q));

  // R2: a valid word in compact mode changes state unless it exactly cancels the shift
  a_r2_valid_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && mode_q == MD_COMPACT && !seed_wr && !reg_we && rsp_data != '0
     && sig_q == '0) |=> sig_q == $past(rsp_data));

endmodule

// File: tb/sig_verifier_tb_top.sv
module sig_verifier_tb_top;
  localparam int W = 16;
  localparam logic [W-1:0] MASK = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W+1:0] reg_rdata;
  logic         rsp_valid = 1'b0;
  logic [W-1:0] rsp_data = '0;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model;
  logic [W-1:0] mpoly;

  always #10 clk = ~clk;

  sig_verifier #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // Bench model: bit-serial view of the shift, tap by tap
  function automatic logic [W-1:0] ref_step(input logic [W-1:0] s,
                                            input logic [W-1:0] p,
                                            input logic [W-1:0] d);
    logic [W-1:0] r;
    logic top;
    top = s[W-1];
    for (int i = W - 1; i > 0; i--) r[i] = s[i-1] ^ (top & p[i]) ^ d[i];
    r[0] = (top & p[0]) ^ d[0];
    return r & MASK;
  endfunction

  task automatic chk(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W+1:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic set_poly(input logic [W-1:0] p);
    wr(2'd0, p);
    mpoly = p;
  endtask

  task automatic set_seed(input logic [W-1:0] s);
    wr(2'd1, s);
    model = s;
  endtask

  task automatic feed(input logic [W-1:0] d);
    push(d);
    model = ref_step(model, mpoly, d);
  endtask

  task automatic t_reset;
    logic [W+1:0] v;
    rd(2'd3, v); chk("R1 reset status", v, '0);
    rd(2'd0, v); chk("R1 reset poly", v, '0);
  endtask

  task automatic t_config;
    logic [W+1:0] v;
    set_poly(16'h1021);
    rd(2'd0, v); chk("R8 poly readback", v, {2'b00, 16'h1021});
    set_seed(16'h8001);
    rd(2'd1, v); chk("R8 seed readback", v, {2'b00, 16'h8001});
    rd(2'd3, v); chk("R3 seed loads signature", v, {2'b00, 16'h8001});
  endtask

  task automatic t_compact;
    logic [W+1:0] v;
    feed(16'h1234); feed(16'hF00F); feed(16'h0000); feed(16'hA5A5);
    rd(2'd3, v); chk("R2 R4 compact stream", v, {2'b00, model});
    repeat (5) @(negedge clk);
    rd(2'd3, v); chk("R2 idle hold", v, {2'b00, model});
  endtask

  task automatic t_verify_pass;
    logic [W+1:0] v;
    wr(2'd2, model);
    rd(2'd2, v); chk("R8 golden readback", v, {2'b00, model});
    wr(2'd3, 16'h0001);
    rd(2'd3, v); chk("R5 done not yet at cmd edge", v, {2'b00, model});
    @(negedge clk);
    rd(2'd3, v); chk("R5 R6 verify pass", v, {2'b11, model});
  endtask

  task automatic t_ignore;
    logic [W+1:0] v;
    push(16'h7777); push(16'h0F0F);
    rd(2'd3, v); chk("R7 words ignored in verify", v, {2'b11, model});
  endtask

  task automatic t_verify_fail;
    logic [W+1:0] v;
    set_seed(16'hC3C3);
    rd(2'd3, v); chk("R3 seed clears flags", v, {2'b00, 16'hC3C3});
    wr(2'd3, 16'h0000);
    feed(16'h0101); feed(16'hFFFF);
    wr(2'd2, model ^ 16'h0004);
    wr(2'd3, 16'h0001);
    @(negedge clk);
    rd(2'd3, v); chk("R6 verify mismatch", v, {2'b10, model});
  endtask

  task automatic t_resume;
    logic [W+1:0] v;
    wr(2'd3, 16'h0000);
    feed(16'h4321);
    rd(2'd3, v); chk("R9 compact resumes, flags kept", v, {2'b10, model});
  endtask

  task automatic t_seed_vs_valid;
    logic [W+1:0] v;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h9ABC;
    rsp_valid = 1'b1; rsp_data = 16'hFFFF;
    @(negedge clk);
    reg_we = 1'b0; rsp_valid = 1'b0;
    model = 16'h9ABC;
    rd(2'd3, v); chk("R10 seed beats valid", v, {2'b00, 16'h9ABC});
  endtask

  task automatic t_poly_matters;
    logic [W+1:0] v;
    logic [W-1:0] sig_a;
    set_poly(16'h8005);
    set_seed(16'hFFFF);
    feed(16'h1111); feed(16'h2222); feed(16'h3333);
    rd(2'd3, v); chk("R4 poly A signature", v, {2'b00, model});
    sig_a = model;
    set_poly(16'h002D);
    set_seed(16'hFFFF);
    feed(16'h1111); feed(16'h2222); feed(16'h3333);
    rd(2'd3, v); chk("R4 poly B signature", v, {2'b00, model});
    chk("R4 polys differ", {1'b0, (sig_a != model), 16'h0}, {2'b01, 16'h0});
  endtask

  initial begin
    model = '0; mpoly = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_config;
    t_compact;
    t_verify_pass;
    t_ignore;
    t_verify_fail;
    t_resume;
    t_seed_vs_valid;
    t_poly_matters;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule